// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Timer

This block is a clocked timer that produces the four gate commands of a full-bridge power stage. The first leg (drive A and drive B) is a fixed square wave: drive A is on for one whole oscillator period and drive B is on for the next one. Each of them therefore runs near 50% duty at half the oscillator rate. The second leg (drive C and drive D) has the same shape but lags the first leg by a programmable number of clock cycles. The power delivered to the transformer is set by how long the diagonal pairs (A with D, B with C) overlap, so a shift of zero gives 0% effective duty and a shift of one full period gives 100%.

Each leg has its own dead-time value. It holds the incoming output of that leg low for a set number of clocks after the leg switches, so the two switches of one leg are never commanded on together. The oscillator period is a count of clock cycles. An on-chip counter provides the timebase and flags the start of each period with a one-cycle sync pulse. A rising edge on an external sync input restarts the period at once, so several converters can be locked to one master. The shift command is captured only when a period begins. Dropping the enable input forces all four drives low in the same cycle.

Top module: `psfb_pwm_core`

## Requirements
- R1: The period in clocks is `period_i`, with values below 2 treated as 2. The first leg's state flips once at every period start, so drive A is on for one period and drive B for the next. Over any window of two periods, each of them is on for P minus the A/B dead time.
- R2: The second leg lags the first by S clocks, where S is the captured shift. With dead times a and c, the number of cycles in two periods where A and D are both on equals max(0, min(S−a, P−c)). The same count applies to B with C. S=0 puts the legs in phase and S=P puts them in antiphase.
- R3: The A/B dead time `dead_ab_i` and the C/D dead time `dead_cd_i` act independently. After a leg switches, the output that is turning on stays low for exactly that leg's dead time in clocks.
- R4: The two drives of one leg are never high in the same cycle. Dead time is applied only within a leg.
- R5: A dead time of 0 bypasses delay insertion, so the leg's two drives are exact complements while enabled.
- R6: `phase_i` is captured only when a new period starts, and any value above P is treated as P. A change in the middle of a period leaves the second leg's switching point in that period unchanged.
- R7: `sync_o` is high for exactly one clock in each period, in the first clock of the period.
- R8: A rising edge on `ext_sync_i` starts a new period. `sync_o` is high in the next clock and again P clocks after that. Holding the input high does not retrigger.
- R9: While `enable_i` is low, all four drives are low in the same clock, and the timebase and `sync_o` keep running.
- R10: A dead time of P or more is treated as P−1, so each drive still turns on for one clock per half cycle.
- R11: During reset the counter is at the start of a period, `sync_o` is high, and with non-zero dead times all four drives are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Oscillator period in clocks |
| phase_i | input | CNT_W | Second-leg lag in clocks, 0..period |
| dead_ab_i | input | CNT_W | Dead time for drives A/B, 0 = bypass |
| dead_cd_i | input | CNT_W | Dead time for drives C/D, 0 = bypass |
| enable_i | input | 1 | High lets the drives switch |
| ext_sync_i | input | 1 | Rising edge restarts the period |
| drv_a_o | output | 1 | First leg, high-side command |
| drv_b_o | output | 1 | First leg, low-side command |
| drv_c_o | output | 1 | Second leg, high-side command |
| drv_d_o | output | 1 | Second leg, low-side command |
| sync_o | output | 1 | One-clock pulse at each period start |

## Verification
The bench measures on-times and diagonal overlaps over two full periods for shifts of zero, mid-range, full period and above period. A design that mixed up the lag direction, or clamped the shift to P−1, would give overlap counts off by the dead time or short of 100%. A design that took the phase command at once would move the second leg's edge within the same period, and the bench catches this by sampling C on each side of the old and new switch points. It also drives dead times of zero, which would overlap the two drives if they were not applied in the same cycle, and of more than a period, which would silence a drive if they were not saturated. Finally it checks external sync retrigger, a held sync level, and disable timing. A block that retriggered on a level, or registered the enable, would misplace `sync_o` or leave a drive high for one extra clock.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

    // Leg indices used by the top-level generate loop.
    typedef enum logic {
        LEG_AB = 1'b0,
        LEG_CD = 1'b1
    } leg_e;

    localparam int unsigned LEG_COUNT = 2;

    // Smallest period the timebase will run with.
    localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic             ext_sync_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             half_o,
    output logic [CNT_W-1:0] shift_o,
    output logic [CNT_W-1:0] per_o,
    output logic             sync_o
);
    import psfb_pkg::*;

    localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic [CNT_W-1:0] shift;
        logic             ext_prev;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] phase_sat;
    logic             ext_rise;
    logic             wrap;

    assign per_eff   = (period_i < PER_FLOOR) ? PER_FLOOR : period_i;
    assign phase_sat = (phase_i > per_eff) ? per_eff : phase_i;

    always_comb begin
        st_d          = st_q;
        ext_rise      = ext_sync_i & ~st_q.ext_prev;
        wrap          = (st_q.cnt >= (per_eff - ONE)) | ext_rise;
        st_d.ext_prev = ext_sync_i;
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.half  = ~st_q.half;
            st_d.shift = phase_sat;
        end else begin
            st_d.cnt   = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign half_o  = st_q.half;
    assign shift_o = st_q.shift;
    assign per_o   = per_eff;
    assign sync_o  = (st_q.cnt == '0);

    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= (per_eff - ONE)) |=> (st_q.cnt == '0)); // R1
    AST_HALF_FLIP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.half) |-> sync_o); // R1
    AST_SHIFT_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_o |-> $stable(st_q.shift)); // R6
    AST_EXT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_sync_i) |=> sync_o); // R8

endmodule

// File: rtl/psfb_phase_gen.sv
module psfb_phase_gen #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             half_i,
    input  logic [CNT_W-1:0] shift_i,
    input  logic [CNT_W-1:0] per_i,
    output logic             raw_ab_o,
    output logic             raw_cd_o
);
    localparam int unsigned POS_W = CNT_W + 1;

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] two_per;
    logic [POS_W-1:0] shift_x;
    logic [POS_W-1:0] per_x;
    logic [POS_W-1:0] lagged;

    // Position inside the two-period frame; the lagged leg sees it minus the shift.
    always_comb begin
        per_x   = {1'b0, per_i};
        shift_x = {1'b0, shift_i};
        two_per = {per_i, 1'b0};
        pos     = {1'b0, cnt_i} + (half_i ? per_x : '0);
        if (pos >= shift_x) begin
            lagged = pos - shift_x;
        end else begin
            lagged = pos + two_per - shift_x;
        end
    end

    assign raw_ab_o = ~half_i;
    assign raw_cd_o = (lagged < per_x);

    AST_ZERO_SHIFT_INPHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i == '0) |-> (raw_cd_o == raw_ab_o)); // R2
    AST_FULL_SHIFT_ANTIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i == per_i) |-> (raw_cd_o != raw_ab_o)); // R2

endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] dt_i,
    input  logic             en_i,
    output logic             hi_o,
    output logic             lo_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] run;
    } db_state_t;

    db_state_t        st_d, st_q;
    logic [CNT_W-1:0] age;
    logic             settled;

    always_comb begin
        st_d      = st_q;
        age       = (raw_i != st_q.prev) ? '0 : st_q.run;
        settled   = (age >= dt_i);
        st_d.prev = raw_i;
        st_d.run  = settled ? age : age + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = en_i &  raw_i & settled;
    assign lo_o = en_i & ~raw_i & settled;

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o)); // R4
    AST_GAP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi_o) && en_i && (dt_i != '0)) |-> !lo_o); // R3
    AST_GAP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lo_o) && en_i && (dt_i != '0)) |-> !hi_o); // R3

endmodule

// File: rtl/psfb_pwm_core.sv
module psfb_pwm_core #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] dead_ab_i,
    input  logic [CNT_W-1:0] dead_cd_i,
    input  logic             enable_i,
    input  logic             ext_sync_i,
    output logic             drv_a_o,
    output logic             drv_b_o,
    output logic             drv_c_o,
    output logic             drv_d_o,
    output logic             sync_o
);
    import psfb_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             half;
    logic [CNT_W-1:0] shift;
    logic [CNT_W-1:0] per_eff;
    logic             raw_ab;
    logic             raw_cd;

    logic [CNT_W-1:0] dt_req [LEG_COUNT];
    logic [CNT_W-1:0] dt_eff [LEG_COUNT];
    logic             leg_raw[LEG_COUNT];
    logic             leg_hi [LEG_COUNT];
    logic             leg_lo [LEG_COUNT];

    psfb_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .phase_i    (phase_i),
        .ext_sync_i (ext_sync_i),
        .cnt_o      (cnt),
        .half_o     (half),
        .shift_o    (shift),
        .per_o      (per_eff),
        .sync_o     (sync_o)
    );

    psfb_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .half_i   (half),
        .shift_i  (shift),
        .per_i    (per_eff),
        .raw_ab_o (raw_ab),
        .raw_cd_o (raw_cd)
    );

    assign dt_req[LEG_AB]  = dead_ab_i;
    assign dt_req[LEG_CD]  = dead_cd_i;
    assign leg_raw[LEG_AB] = raw_ab;
    assign leg_raw[LEG_CD] = raw_cd;

    for (genvar g = 0; g < LEG_COUNT; g++) begin : g_leg
        // Saturate so each side still gets at least one on-cycle per half.
        assign dt_eff[g] = (dt_req[g] >= per_eff) ? (per_eff - ONE) : dt_req[g];

        psfb_deadband #(.CNT_W(CNT_W)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (leg_raw[g]),
            .dt_i  (dt_eff[g]),
            .en_i  (enable_i),
            .hi_o  (leg_hi[g]),
            .lo_o  (leg_lo[g])
        );
    end

    assign drv_a_o = leg_hi[LEG_AB];
    assign drv_b_o = leg_lo[LEG_AB];
    assign drv_c_o = leg_hi[LEG_CD];
    assign drv_d_o = leg_lo[LEG_CD];

    AST_DISABLE_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !(drv_a_o || drv_b_o || drv_c_o || drv_d_o)); // R9
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !ext_sync_i) |=> !sync_o); // R7

endmodule

// File: tb/sim_psfb_pwm_core.sv
`timescale 1ns/1ps
module sim_psfb_pwm_core;

    localparam int W = 8;
    localparam int NVEC = 7;
    // columns: period, phase, dead_ab, dead_cd, exp A on, exp C on, exp diagonal overlap
    localparam int VEC [0:NVEC-1][0:6] = '{
        '{10,  0,  2, 2,  8,  8,  0},
        '{10,  5,  2, 3,  8,  7,  3},
        '{10, 10,  2, 3,  8,  7,  7},
        '{20, 15,  0, 0, 20, 20, 15},
        '{12, 30,  1, 1, 11, 11, 11},
        '{10,  4, 50, 4,  1,  6,  0},
        '{16,  8,  3, 1, 13, 15,  5}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] period_i = 8'd10;
    logic [W-1:0] phase_i = 8'd0;
    logic [W-1:0] dead_ab_i = 8'd2;
    logic [W-1:0] dead_cd_i = 8'd2;
    logic         enable_i = 1'b1;
    logic         ext_sync_i = 1'b0;
    logic         drv_a_o, drv_b_o, drv_c_o, drv_d_o, sync_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    psfb_pwm_core #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .phase_i(phase_i),
        .dead_ab_i(dead_ab_i), .dead_cd_i(dead_cd_i), .enable_i(enable_i),
        .ext_sync_i(ext_sync_i), .drv_a_o(drv_a_o), .drv_b_o(drv_b_o),
        .drv_c_o(drv_c_o), .drv_d_o(drv_d_o), .sync_o(sync_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_o);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ca, cb, cc, cd, dad, dbc, ovl, ns;
        int c4, c5, c7, c8;
        // R11: reset state
        step(3);
        chk("R11 drives low in reset", int'(drv_a_o | drv_b_o | drv_c_o | drv_d_o), 0);
        chk("R11 sync high in reset", int'(sync_o), 1);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            int p;
            p = VEC[v][0];
            period_i  = W'(VEC[v][0]);
            phase_i   = W'(VEC[v][1]);
            dead_ab_i = W'(VEC[v][2]);
            dead_cd_i = W'(VEC[v][3]);
            step(6 * p);
            ca = 0; cb = 0; cc = 0; cd = 0; dad = 0; dbc = 0; ovl = 0; ns = 0;
            for (int k = 0; k < 2 * p; k++) begin
                @(negedge clk);
                ca  += int'(drv_a_o);
                cb  += int'(drv_b_o);
                cc  += int'(drv_c_o);
                cd  += int'(drv_d_o);
                dad += int'(drv_a_o & drv_d_o);
                dbc += int'(drv_b_o & drv_c_o);
                ovl += int'(drv_a_o & drv_b_o) + int'(drv_c_o & drv_d_o);
                ns  += int'(sync_o);
            end
            chk($sformatf("R1/R3/R5/R10 vec%0d A on-time", v), ca, VEC[v][4]);
            chk($sformatf("R1/R3/R5/R10 vec%0d B on-time", v), cb, VEC[v][4]);
            chk($sformatf("R3/R5 vec%0d C on-time", v), cc, VEC[v][5]);
            chk($sformatf("R3/R5 vec%0d D on-time", v), cd, VEC[v][5]);
            chk($sformatf("R2 vec%0d A&D overlap", v), dad, VEC[v][6]);
            chk($sformatf("R2 vec%0d B&C overlap", v), dbc, VEC[v][6]);
            chk($sformatf("R4 vec%0d same-leg overlap", v), ovl, 0);
            chk($sformatf("R7 vec%0d sync pulses", v), ns, 2);
        end

        // R6: mid-period phase change takes effect only at next period start
        period_i = 8'd10; phase_i = 8'd5; dead_ab_i = 8'd2; dead_cd_i = 8'd0;
        step(60);
        wait_sync();
        phase_i = 8'd8;
        step(4); c4 = int'(drv_c_o);
        step(1); c5 = int'(drv_c_o);
        chk("R6 old edge kept in current period", int'(c4 != c5), 1);
        step(5);
        chk("R7 period start after 10 clocks", int'(sync_o), 1);
        step(4); c4 = int'(drv_c_o);
        step(1); c5 = int'(drv_c_o);
        step(2); c7 = int'(drv_c_o);
        step(1); c8 = int'(drv_c_o);
        chk("R6 old edge gone next period", int'(c4 != c5), 0);
        chk("R2 new edge at shift 8", int'(c7 != c8), 1);
        chk("R5 bypass D is complement of C", int'(drv_c_o ^ drv_d_o), 1);

        // R8: external sync restart, held level does not retrigger
        wait_sync();
        step(3);
        ext_sync_i = 1'b1;
        step(1);
        chk("R8 sync after external edge", int'(sync_o), 1);
        ns = 0;
        for (int k = 0; k < 9; k++) begin
            step(1);
            ns += int'(sync_o);
        end
        chk("R8 held level no retrigger", ns, 0);
        step(1);
        chk("R8 next sync one period later", int'(sync_o), 1);
        ext_sync_i = 1'b0;

        // R9: disable forces all drives low in the same clock
        wait_sync();
        step(2);
        enable_i = 1'b0;
        #1;
        chk("R9 drives low immediately", int'(drv_a_o | drv_b_o | drv_c_o | drv_d_o), 0);
        ca = 0; ns = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            ca += int'(drv_a_o | drv_b_o | drv_c_o | drv_d_o);
            ns += int'(sync_o);
        end
        chk("R9 drives stay low while disabled", ca, 0);
        chk("R9 timebase keeps running", ns, 2);
        enable_i = 1'b1;
        step(40);
        ca = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            ca += int'(drv_a_o);
        end
        chk("R9 A on-time after re-enable", ca, 8);

        finish_run();
    end

endmodule